// File: doc/BRIEF.md
# Streaming Complex Frequency Shifter with Gain

This block moves a stream of complex baseband samples in frequency. Each accepted sample is rotated by a numerically controlled oscillator, then multiplied by a signed fixed-point gain and clipped to the sample range. The oscillator is a phase accumulator that steps by a programmable increment once per accepted sample. Its sine and cosine come from an on-chip quarter-wave table with linear interpolation, so no vendor core is needed.

Samples travel on a valid/ready stream that carries an end-of-packet flag and a 128-bit sideband word. Both ride through the datapath with their sample, so packet boundaries and sideband survive any pattern of stalls. A phase-zero strobe, qualified by the input handshake, restarts the oscillator at exactly the sample it arrives with. The frequency word is taken when a sample is accepted. The gain is applied in the scaling stage and should be changed only while the pipeline is empty.

Top module: `nco_freq_shifter`

## Requirements
- R1: The oscillator phase used for the first sample after reset is 0. Each accepted sample adds `freq_word` (unsigned, 2^32 = one full turn) to the phase, and the phase does not move on cycles without an accepted sample.
- R2: Each output component is within ±8 LSB of the ideal value round(gain·x·e^(j2π·phase/2^32)). It is within ±3 LSB when the gain magnitude is below 1.0.
- R3: Samples carry the real part in bits 31:16 and the imaginary part in bits 15:0, both signed two's complement with 15 fractional bits, on input and output alike.
- R4: `gain` is an 18-bit two's complement number with 15 fractional bits, covering −4.0 to just under +4.0. Negative gains invert the sample.
- R5: After scaling, each component clips to the range −32768 to 32767 and never wraps in sign.
- R6: When `phase_zero` is high on an accepted sample, that sample uses phase 0 and the next accepted sample uses phase `freq_word`.
- R7: Every output beat carries the `in_last` and `in_user` values of its own input sample. The number of output beats equals the number of input beats, with no beat invented.
- R8: While `out_valid` is high and `out_ready` is low, the output beat holds steady. No sample is lost or repeated under random stalls on either side, including one-sample packets.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | Phase increment per accepted sample |
| gain | input | 18 | Signed gain with 15 fractional bits |
| phase_zero | input | 1 | Restart the phase at the sample being accepted |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 32 | Input sample, real in 31:16, imaginary in 15:0 |
| in_last | input | 1 | Last sample of a packet |
| in_user | input | 128 | Sideband word carried with the sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the sample this cycle |
| out_data | output | 32 | Shifted and scaled sample |
| out_last | output | 1 | Last flag of this sample |
| out_user | output | 128 | Sideband word of this sample |

## Verification
The phase restart and the output stall can fall in the same cycle. A `phase_zero` sample can be accepted while the pipeline is filling behind a beat that downstream refuses, and input gaps can push the restarted sample right up against a held output. The bench provokes this by driving the restart strobe mid-packet and at packet start while `out_ready` and `in_valid` both toggle at random. Its scoreboard then expects phase 0 on exactly that sample and `freq_word` on the next, and it separately checks that each held beat stays unchanged until it is taken.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  // Arithmetic shift right with round-half-up.
  function automatic logic signed [63:0] rnd_shr(input logic signed [63:0] v,
                                                 input int unsigned sh);
    logic signed [63:0] half;
    half = 64'sd1 <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // Clip a value into the range of a w-bit two's complement number.
  function automatic logic signed [63:0] clamp_w(input logic signed [63:0] v,
                                                 input int unsigned w);
    logic signed [63:0] hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Entry i of an n-step quarter sine, scaled to amp (series evaluated at elaboration).
  function automatic int qsin_entry(input int i, input int n, input int amp);
    real x, x2, t, s;
    x  = 1.5707963267948966 * real'(i) / real'(n);
    x2 = x * x;
    t  = x;
    s  = x;
    for (int k = 1; k <= 7; k++) begin
      t = -t * x2 / real'((2 * k) * (2 * k + 1));
      s = s + t;
    end
    return $rtoi(s * real'(amp) + 0.5);
  endfunction

endpackage

// File: rtl/nfs_phase_acc.sv
module nfs_phase_acc #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          zero,
  input  logic [PW-1:0] incr,
  output logic [PW-1:0] ph_use
);
  logic [PW-1:0] acc_q;

  // phase applied to the sample being accepted
  assign ph_use = zero ? '0 : acc_q;

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= ph_use + incr;
  end

  // R1: no accepted sample, no phase movement
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));

  // R6: a restart leaves exactly one increment in the accumulator
  assert_zero_restart_R6: assert property (@(posedge clk) disable iff (rst)
    step && zero |=> acc_q == $past(incr));

endmodule

// File: rtl/nfs_sincos.sv
module nfs_sincos #(
  parameter int PW  = 32,
  parameter int AW  = 16,
  parameter int TB  = 7,
  parameter int FB  = 10,
  parameter int AMP = 32767
) (
  input  logic [PW-1:0]        ph,
  output logic signed [AW-1:0] sin_o,
  output logic signed [AW-1:0] cos_o
);
  import nfs_pkg::*;

  localparam int N  = 1 << TB;
  localparam int SH = PW - 2 - TB;   // bits below the table index
  localparam logic signed [63:0] ONE2 = 64'sd1 <<< (2 * AW - 2);
  localparam logic signed [63:0] TOL  = 64'sd1 <<< (2 * AW - 12);

  logic signed [AW-1:0] tbl [0:N];

  generate
    for (genvar i = 0; i <= N; i++) begin : g_tbl
      localparam int VAL = qsin_entry(i, N, AMP);
      assign tbl[i] = AW'(VAL);
    end

    // lane 0 gives sine, lane 1 the same lookup a quarter turn ahead (cosine)
    for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam logic [PW-1:0] OFF = (g == 0) ? '0 : (PW'(1) << (PW - 2));
      logic [PW-1:0]        p;
      logic [PW-2:0]        a, af;
      logic [TB:0]          idx, idx1;
      logic [FB-1:0]        fr;
      logic signed [63:0]   b64, n64, m64;
      logic signed [AW-1:0] val;

      always_comb begin
        p    = ph + OFF;
        a    = {1'b0, p[PW-3:0]};
        af   = p[PW-2] ? (((PW-1)'(1) << (PW - 2)) - a) : a;  // mirror odd quadrants
        idx  = af[PW-2:SH];
        fr   = af[SH-1 -: FB];
        idx1 = (idx == (TB+1)'(N)) ? idx : idx + (TB+1)'(1);
        b64  = 64'(tbl[idx]);
        n64  = 64'(tbl[idx1]);
        m64  = b64 + rnd_shr((n64 - b64) * 64'($signed({1'b0, fr})), FB);
        val  = AW'(p[PW-1] ? -m64 : m64);                      // negate lower half
      end
    end
  endgenerate

  assign sin_o = g_lane[0].val;
  assign cos_o = g_lane[1].val;

  logic signed [63:0] mag2;
  always_comb begin
    mag2 = 64'(sin_o) * 64'(sin_o) + 64'(cos_o) * 64'(cos_o);
    // R2: oscillator output stays on the unit circle
    assert_unit_circle_R2: assert ((mag2 <= ONE2 + TOL) && (mag2 >= ONE2 - TOL));
  end

endmodule

// File: rtl/nfs_mixer.sv
module nfs_mixer #(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic signed [CW-1:0] xr,
  input  logic signed [CW-1:0] xi,
  input  logic signed [AW-1:0] c,
  input  logic signed [AW-1:0] s,
  output logic signed [CW+1:0] yr,
  output logic signed [CW+1:0] yi
);
  import nfs_pkg::*;

  localparam int FRAC = AW - 1;

  logic signed [63:0] r64, i64;

  always_comb begin
    r64 = 64'(xr) * 64'(c) - 64'(xi) * 64'(s);
    i64 = 64'(xr) * 64'(s) + 64'(xi) * 64'(c);
    yr  = (CW+2)'(rnd_shr(r64, FRAC));
    yi  = (CW+2)'(rnd_shr(i64, FRAC));
  end

endmodule

// File: rtl/nfs_scaler.sv
module nfs_scaler #(
  parameter int MW = 18,
  parameter int GW = 18,
  parameter int GF = 15,
  parameter int CW = 16
) (
  input  logic signed [MW-1:0] y,
  input  logic signed [GW-1:0] g,
  output logic signed [CW-1:0] z
);
  import nfs_pkg::*;

  logic signed [63:0] w;

  always_comb begin
    w = rnd_shr(64'(y) * 64'(g), GF);
    z = CW'(clamp_w(w, CW));
    // R5: clipping never flips or loses the sign
    assert_sign_kept_R5: assert ((w > 0) ? (z > 0) : ((w < 0) ? (z < 0) : (z == 0)));
  end

endmodule

// File: rtl/nco_freq_shifter.sv
module nco_freq_shifter #(
  parameter int CW = 16,
  parameter int PW = 32,
  parameter int GW = 18,
  parameter int GF = 15,
  parameter int UW = 128,
  parameter int TB = 7,
  parameter int FB = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PW-1:0]   freq_word,
  input  logic [GW-1:0]   gain,
  input  logic            phase_zero,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2*CW-1:0] in_data,
  input  logic            in_last,
  input  logic [UW-1:0]   in_user,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2*CW-1:0] out_data,
  output logic            out_last,
  output logic [UW-1:0]   out_user
);
  localparam int SW   = 2 * CW;
  localparam int MW   = CW + 2;
  localparam int NST  = 4;
  localparam int AMP  = (1 << (CW - 1)) - 1;
  localparam int CNTW = $clog2(NST + 1) + 1;

  // control and sideband pipeline
  logic          v_q [1:NST];
  logic          l_q [1:NST];
  logic [UW-1:0] u_q [1:NST];

  logic adv, take;
  assign adv      = !v_q[NST] || out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= NST; k++) v_q[k] <= 1'b0;
    end else if (adv) begin
      v_q[1] <= in_valid;
      for (int k = 2; k <= NST; k++) v_q[k] <= v_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      l_q[1] <= in_last;
      u_q[1] <= in_user;
      for (int k = 2; k <= NST; k++) begin
        l_q[k] <= l_q[k-1];
        u_q[k] <= u_q[k-1];
      end
    end
  end

  // stage 1: phase
  logic [PW-1:0] ph_use, ph1;
  logic [SW-1:0] d1, d2;

  nfs_phase_acc #(.PW(PW)) u_acc (
    .clk(clk), .rst(rst), .step(take), .zero(phase_zero),
    .incr(freq_word), .ph_use(ph_use)
  );

  // stage 2: oscillator
  logic signed [CW-1:0] sn_w, cs_w, sn2, cs2;

  nfs_sincos #(.PW(PW), .AW(CW), .TB(TB), .FB(FB), .AMP(AMP)) u_osc (
    .ph(ph1), .sin_o(sn_w), .cos_o(cs_w)
  );

  // stage 3: complex rotation
  logic signed [MW-1:0] yr_w, yi_w, yr3, yi3;

  nfs_mixer #(.CW(CW), .AW(CW)) u_mix (
    .xr($signed(d2[SW-1:CW])), .xi($signed(d2[CW-1:0])),
    .c(cs2), .s(sn2), .yr(yr_w), .yi(yi_w)
  );

  // stage 4: gain and clip
  logic signed [CW-1:0] zr_w, zi_w, zr4, zi4;

  nfs_scaler #(.MW(MW), .GW(GW), .GF(GF), .CW(CW)) u_sc_re (
    .y(yr3), .g($signed(gain)), .z(zr_w)
  );
  nfs_scaler #(.MW(MW), .GW(GW), .GF(GF), .CW(CW)) u_sc_im (
    .y(yi3), .g($signed(gain)), .z(zi_w)
  );

  always_ff @(posedge clk) begin
    if (adv) begin
      ph1 <= ph_use;
      d1  <= in_data;
      d2  <= d1;
      sn2 <= sn_w;
      cs2 <= cs_w;
      yr3 <= yr_w;
      yi3 <= yi_w;
      zr4 <= zr_w;
      zi4 <= zi_w;
    end
  end

  assign out_valid = v_q[NST];
  assign out_last  = l_q[NST];
  assign out_user  = u_q[NST];
  assign out_data  = {zr4, zi4};

  // beats inside the block, for the checks below
  logic [CNTW-1:0] inflight;
  logic            leave;
  assign leave = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst)                inflight <= '0;
    else if (take && !leave) inflight <= inflight + CNTW'(1);
    else if (!take && leave) inflight <= inflight - CNTW'(1);
  end

  // R8: a refused beat is held unchanged
  assert_hold_out_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_last) && $stable(out_user));

  // R8: never more beats inside than pipeline stages
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNTW'(NST));

  // R7: no output beat without a matching input beat
  assert_no_phantom_R7: assert property (@(posedge clk) disable iff (rst)
    inflight == '0 |-> !out_valid);

endmodule

// File: tb/test_nco_freq_shifter.sv
module test_nco_freq_shifter;
  localparam int CW = 16;
  localparam int PW = 32;
  localparam int GW = 18;
  localparam int UW = 128;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [PW-1:0]   freq_word = '0;
  logic [GW-1:0]   gain = 18'd32768;
  logic            phase_zero = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [2*CW-1:0] in_data = '0;
  logic            in_last = 1'b0;
  logic [UW-1:0]   in_user = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [2*CW-1:0] out_data;
  logic            out_last;
  logic [UW-1:0]   out_user;

  nco_freq_shifter i_nco_freq_shifter (
    .clk(clk), .rst(rst), .freq_word(freq_word), .gain(gain), .phase_zero(phase_zero),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_user(in_user), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_user(out_user)
  );

  typedef struct {
    int            re;
    int            im;
    int            tol;
    bit            last;
    logic [UW-1:0] user;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  int   gap_pct = 0;
  int   rdy_pct = 100;
  bit [31:0] m_ph = '0;
  bit [31:0] m_inc = '0;
  int   m_gain = 32768;
  int   n_smp = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int clip16(input real v);
    real r;
    r = $floor(v + 0.5);
    if (r > 32767.0) return 32767;
    if (r < -32768.0) return -32768;
    return $rtoi(r);
  endfunction

  // driver: offers one sample, records what must come out
  task automatic send(input int xr, input int xi, input bit last,
                      input logic [UW-1:0] user, input bit zero);
    exp_t      e;
    bit [31:0] use_ph;
    real       ang, mr, mi, gr;
    while ($urandom_range(0, 99) < gap_pct) @(negedge clk);
    in_valid   = 1'b1;
    in_data    = {xr[15:0], xi[15:0]};
    in_last    = last;
    in_user    = user;
    phase_zero = zero;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    use_ph = zero ? 32'd0 : m_ph;
    m_ph   = use_ph + m_inc;
    ang    = TWO_PI * real'(use_ph) / 4294967296.0;
    mr     = real'(xr) * $cos(ang) - real'(xi) * $sin(ang);
    mi     = real'(xr) * $sin(ang) + real'(xi) * $cos(ang);
    gr     = real'(m_gain) / 32768.0;
    e.re   = clip16(mr * gr);
    e.im   = clip16(mi * gr);
    e.tol  = (m_gain < 32768 && m_gain > -32768) ? 3 : 8;
    e.last = last;
    e.user = user;
    e.tag  = cur_tag;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid   = 1'b0;
    phase_zero = 1'b0;
  endtask

  string cur_tag = "R3";

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input real f, input int g);
    longint lv;
    drain();
    lv        = longint'($floor(f * 4294967296.0));
    m_inc     = 32'(lv);
    freq_word = m_inc;
    m_gain    = g;
    gain      = 18'(g);
  endtask

  task automatic packet(input int len, input real fin, input real amp, input int zero_at);
    for (int i = 0; i < len; i++) begin
      int xr, xi;
      xr = $rtoi(amp * 32767.0 * $cos(TWO_PI * fin * real'(n_smp)));
      xi = $rtoi(amp * 32767.0 * $sin(TWO_PI * fin * real'(n_smp)));
      n_smp++;
      send(xr, xi, i == len - 1, {$urandom, $urandom, $urandom, $urandom}, i == zero_at);
    end
  endtask

  // monitor: scoreboard compare and hold check
  bit              held = 1'b0;
  logic [2*CW-1:0] h_data;
  logic            h_last;
  logic [UW-1:0]   h_user;

  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 99) < rdy_pct);
      #2;
      if (!rst) begin
        if (held)
          check(out_valid && out_data == h_data && out_last == h_last && out_user == h_user,
                "R8", "held beat changed", longint'(out_data), longint'(h_data));
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7", "beat with no input", longint'(out_data), 0);
          end else begin
            exp_t e;
            int   ar, ai, dr, di;
            e  = exp_q.pop_front();
            ar = int'($signed(out_data[31:16]));
            ai = int'($signed(out_data[15:0]));
            dr = (ar > e.re) ? ar - e.re : e.re - ar;
            di = (ai > e.im) ? ai - e.im : e.im - ai;
            check(dr <= e.tol, e.tag, "real part", ar, e.re);
            check(di <= e.tol, e.tag, "imag part", ai, e.im);
            check(out_last == e.last, "R7", "last flag", longint'(out_last), longint'(e.last));
            check(out_user == e.user, "R7", "sideband low word",
                  longint'(out_user[63:0]), longint'(e.user[63:0]));
          end
        end
        held   = out_valid && !out_ready;
        h_data = out_data;
        h_last = out_last;
        h_user = out_user;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual %0d pending expected 0", exp_q.size());
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);
    @(negedge clk);

    // plain pass-through: zero shift, unity gain (R3)
    cur_tag = "R3";
    set_cfg(0.0, 32768);
    packet(16, 1.0 / 16.0, 0.75, -1);

    // fixed shift over several packets (R1)
    cur_tag = "R1";
    set_cfg(0.17, 32768);
    for (int k = 0; k < 3; k++) packet(7, 0.04, 0.7, -1);

    // gain below one with mild stalls, tight tolerance (R2)
    cur_tag = "R2";
    gap_pct = 20; rdy_pct = 80;
    set_cfg(0.23, 24576);
    packet(12, 0.05, 0.9, -1);

    // negative gain above one in magnitude (R4)
    cur_tag = "R4";
    set_cfg(-0.11, -40960);
    packet(10, 0.1, 0.5, -1);

    // clipping at both gain extremes (R5)
    cur_tag = "R5";
    set_cfg(0.07, 131071);
    packet(12, 0.03, 0.5, -1);
    set_cfg(0.0, -131072);
    packet(8, 0.12, 0.5, -1);

    // phase restart mid-packet and on a first sample, under stalls (R6)
    cur_tag = "R6";
    gap_pct = 30; rdy_pct = 50;
    set_cfg(0.1, 32768);
    packet(10, 0.02, 0.8, 4);
    packet(5, 0.02, 0.8, 0);

    // heavy stalls, one- and three-sample packets (R8)
    cur_tag = "R8";
    gap_pct = 40; rdy_pct = 40;
    set_cfg(0.29, 20000);
    for (int k = 0; k < 20; k++) packet((k % 3 == 0) ? 1 : 3, 0.07, 0.6, (k % 5 == 0) ? 0 : -1);

    drain();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule